// File: doc/BRIEF.md
# Microcoded 4-bit Accumulator Processor

This block is a small processor built around one 4-bit accumulator. Its program and its data share a 256-word by 8-bit RAM. Each instruction word holds a 4-bit opcode in its upper nibble and a 4-bit operand in its lower nibble, which gives sixteen opcodes. After an instruction is fetched, a 64-word control store steps through four micro-steps for that opcode. Each control word selects the memory read, the operand latch, the accumulator operation, the store, the address register load and the program-counter updates. The word index is the opcode times four plus the step.

The jumps are deliberately narrow. Two opcodes each replace one nibble of the program counter. The conditional jumps load all eight bits, but only while the accumulator is zero. One store opcode writes to an address that it first fetches from memory. A non-maskable interrupt input is synchronized and edge-detected. Once the running instruction has completed, the interrupt loads the program counter from an 8-bit switch vector. No return address is saved.

The processor runs while `run` is high. When `run` falls, it finishes the current instruction and then parks before the next fetch. While parked, a load port owns the RAM, so a host can write a program and read memory back.

Top module: `acc4_cpu`

## Requirements
- R1: Reset clears the program counter, the accumulator and the address register, and sets the zero flag. While `run` is low before a fetch, no instruction starts and the program counter holds.
- R2: An instruction word is {opcode[7:4], operand[3:0]}. The program counter increments right after the fetch. Each instruction takes 6 clock cycles and signals its end with a one-cycle `retire` pulse. An operand used as a memory address means address {4'b0000, operand}.
- R3: Opcodes 0x0 and 0x1 load the accumulator from the low nibble of mem[op] or from op. Opcodes 0x2 and 0x3 add mem[op] or op. Opcodes 0x4 and 0x5 subtract mem[op] or op. The arithmetic wraps modulo 16, and `zero_o` is high exactly when the accumulator is 0.
- R4: Opcode 0x7 writes {4'b0000, acc} to mem[op]. Opcode 0x6 writes the same value to the 8-bit address held in mem[op]. A store leaves the accumulator unchanged.
- R5: Opcode 0x9 loads the address register with {4'b0000, op}. Opcode 0x8 loads it with the full byte mem[op].
- R6: Opcodes 0xB and 0xA replace PC[3:0] with op or with the low nibble of mem[op]. Opcodes 0xD and 0xC replace PC[7:4] in the same way. The other nibble keeps its value after the increment.
- R7: Opcodes 0xF and 0xE load the PC with {4'b0000, op} or with mem[op], but only when the accumulator is zero. Otherwise execution falls through.
- R8: A rising edge on `nmi_req` loads the PC with `nmi_vec` at the end of the instruction that is running or next. One edge causes exactly one such jump, however long the request stays high.
- R9: While the processor is parked, `ld_we` writes `ld_wdata` to `ld_addr`. `ld_rdata` returns mem[ld_addr] one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Allows the next instruction fetch |
| ld_we | input | 1 | Load-port write enable (honoured while parked) |
| ld_addr | input | 8 | Load-port address |
| ld_wdata | input | 8 | Load-port write data |
| ld_rdata | output | 8 | Load-port registered read data |
| nmi_req | input | 1 | Asynchronous interrupt request, rising-edge sensitive |
| nmi_vec | input | 8 | Interrupt target address from switches |
| acc_o | output | 4 | Accumulator |
| zero_o | output | 1 | Accumulator-is-zero flag |
| pc_o | output | 8 | Program counter |
| areg_o | output | 8 | Address register |
| retire | output | 1 | One-cycle pulse after each instruction ends |

## Verification
Every architectural result appears in the same cycle as `retire`, which comes 6 cycles after the preceding one. The bench therefore waits for that pulse at a falling edge and samples the accumulator, the flag, the program counter and the address register there. It also measures the gap between two pulses. Stored bytes are read through the load port once the processor has parked. The read data is sampled one full clock after the address is driven. The interrupt passes through a two-stage synchronizer and then takes effect only at an instruction end. For that reason the bench allows up to three retirements for the vector to appear, and then requires that no second jump follows while the request stays high.

// File: rtl/acc4_pkg.sv
package acc4_pkg;

  typedef enum logic [1:0] {ACC_KEEP, ACC_LOAD, ACC_ADD, ACC_SUB} acc_fn_e;

  typedef enum logic [1:0] {PH_F0, PH_F1, PH_EX} phase_e;

  typedef struct packed {
    logic    rd_opnd;  // read mem[{0,op}]
    logic    latch;    // capture read data
    logic    use_mem;  // source is latched byte, else operand
    acc_fn_e acc_fn;
    logic    st_en;
    logic    st_ind;   // store address from latched byte
    logic    ar_ld;
    logic    pc_lo;
    logic    pc_hi;
    logic    pc_jz;
    logic    last;
  } uword_t;

  // Control store contents: opcode bit 0 low selects the memory operand.
  function automatic uword_t ucode_entry(input logic [3:0] opc, input logic [1:0] stp);
    uword_t w;
    logic   memv;
    w    = '0;
    memv = ~opc[0];
    case (stp)
      2'd0: w.rd_opnd = memv;
      2'd1: w.latch   = memv;
      2'd2: begin
        w.use_mem = memv;
        case (opc[3:1])
          3'd0: w.acc_fn = ACC_LOAD;
          3'd1: w.acc_fn = ACC_ADD;
          3'd2: w.acc_fn = ACC_SUB;
          3'd3: begin w.st_en = 1'b1; w.st_ind = memv; w.use_mem = 1'b0; end
          3'd4: w.ar_ld = 1'b1;
          3'd5: w.pc_lo = 1'b1;
          3'd6: w.pc_hi = 1'b1;
          default: w.pc_jz = 1'b1;
        endcase
      end
      default: w.last = 1'b1;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/acc4_ucode.sv
module acc4_ucode
  import acc4_pkg::*;
#(
  parameter int OPC_W  = 4,
  parameter int STEP_W = 2
) (
  input  logic [OPC_W+STEP_W-1:0] addr,
  output uword_t                  word
);
  localparam int DEPTH = 1 << (OPC_W + STEP_W);

  uword_t rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    localparam logic [OPC_W+STEP_W-1:0] IDX = i[OPC_W+STEP_W-1:0];
    assign rom[i] = ucode_entry(IDX[OPC_W+STEP_W-1 -: 4], IDX[1:0]);
  end

  assign word = rom[addr];
endmodule

// File: rtl/acc4_ram.sv
module acc4_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/acc4_nmi.sv
module acc4_nmi (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic take,
  output logic pending
);
  logic s1, s2, s3, rise;

  assign rise = s2 & ~s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0; pending <= 1'b0;
    end else begin
      s1 <= req; s2 <= s1; s3 <= s2;
      if (take) pending <= 1'b0;
      if (rise) pending <= 1'b1;
    end
  end

  AST_NMI_HELD: assert property (@(posedge clk) disable iff (rst)
    (pending && !take) |=> pending); // R8
  AST_NMI_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (take && !rise) |=> !pending); // R8
endmodule

// File: rtl/acc4_cpu.sv
module acc4_cpu
  import acc4_pkg::*;
#(
  parameter int NIB  = 4,
  parameter int AW   = 8,
  parameter int STEPS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [2*NIB-1:0] ld_wdata,
  output logic [2*NIB-1:0] ld_rdata,
  input  logic          nmi_req,
  input  logic [AW-1:0] nmi_vec,
  output logic [NIB-1:0] acc_o,
  output logic          zero_o,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] areg_o,
  output logic          retire
);
  localparam int WW     = 2 * NIB;
  localparam int STEP_W = $clog2(STEPS);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);
  localparam logic [STEP_W-1:0] EXEC_STEP = STEP_W'(2);

  phase_e            phase;
  logic [STEP_W-1:0] step;
  logic [WW-1:0]     ir, mdr;
  logic [NIB-1:0]    acc_q, acc_nx;
  logic [AW-1:0]     pc_q, areg_q;
  logic              zero_q, retire_q;

  uword_t            cw;
  logic              in_ex, cpu_own, nmi_pend, nmi_take;
  logic [NIB-1:0]    opnd;
  logic [AW-1:0]     src8, st_addr;
  logic [NIB-1:0]    src4;
  logic              ram_we;
  logic [AW-1:0]     ram_addr;
  logic [WW-1:0]     ram_wdata, ram_rdata;

  assign opnd  = ir[NIB-1:0];
  assign in_ex = (phase == PH_EX);

  acc4_ucode #(.OPC_W(NIB), .STEP_W(STEP_W)) i_ucode (
    .addr({ir[WW-1:NIB], step}),
    .word(cw)
  );

  acc4_nmi i_nmi (
    .clk(clk), .rst(rst), .req(nmi_req), .take(nmi_take), .pending(nmi_pend)
  );

  assign nmi_take = in_ex && cw.last && nmi_pend;

  // Operand source
  assign src8    = cw.use_mem ? mdr : {{(AW-NIB){1'b0}}, opnd};
  assign src4    = src8[NIB-1:0];
  assign st_addr = cw.st_ind ? mdr : {{(AW-NIB){1'b0}}, opnd};

  always_comb begin
    acc_nx = acc_q;
    if (in_ex && step == EXEC_STEP) begin
      case (cw.acc_fn)
        ACC_LOAD: acc_nx = src4;
        ACC_ADD:  acc_nx = acc_q + src4;
        ACC_SUB:  acc_nx = acc_q - src4;
        default:  acc_nx = acc_q;
      endcase
    end
  end

  // RAM port sharing: the load port owns it only while parked
  assign cpu_own = !(phase == PH_F0 && !run);

  always_comb begin
    ram_we    = 1'b0;
    ram_addr  = ld_addr;
    ram_wdata = ld_wdata;
    if (!cpu_own) begin
      ram_we = ld_we;
    end else if (phase == PH_F0) begin
      ram_addr = pc_q;
    end else if (in_ex && cw.rd_opnd) begin
      ram_addr = {{(AW-NIB){1'b0}}, opnd};
    end else if (in_ex && cw.st_en) begin
      ram_we    = 1'b1;
      ram_addr  = st_addr;
      ram_wdata = {{(WW-NIB){1'b0}}, acc_q};
    end
  end

  acc4_ram #(.AW(AW), .DW(WW)) i_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_rdata)
  );

  // Sequencer and architectural state
  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_F0;
      step     <= '0;
      ir       <= '0;
      mdr      <= '0;
      acc_q    <= '0;
      zero_q   <= 1'b1;
      pc_q     <= '0;
      areg_q   <= '0;
      retire_q <= 1'b0;
    end else begin
      retire_q <= 1'b0;
      acc_q    <= acc_nx;
      zero_q   <= (acc_nx == '0);
      case (phase)
        PH_F0: if (run) phase <= PH_F1;
        PH_F1: begin
          ir    <= ram_rdata;
          pc_q  <= pc_q + 1'b1;
          step  <= '0;
          phase <= PH_EX;
        end
        default: begin
          if (cw.latch) mdr <= ram_rdata;
          if (step == EXEC_STEP) begin
            if (cw.ar_ld) areg_q <= src8;
            if (cw.pc_lo) pc_q[NIB-1:0] <= src4;
            if (cw.pc_hi) pc_q[AW-1:AW-NIB] <= src4;
            if (cw.pc_jz && acc_q == '0) pc_q <= src8;
          end
          if (step == LAST_STEP) begin
            if (nmi_take) pc_q <= nmi_vec;
            retire_q <= 1'b1;
            phase    <= PH_F0;
          end else begin
            step <= step + 1'b1;
          end
        end
      endcase
    end
  end

  assign ld_rdata = ram_rdata;
  assign acc_o    = acc_q;
  assign zero_o   = zero_q;
  assign pc_o     = pc_q;
  assign areg_o   = areg_q;
  assign retire   = retire_q;

  AST_PARK_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_F0 && !run) |=> $stable(pc_q)); // R1
  AST_RETIRE_GAP: assert property (@(posedge clk) disable iff (rst)
    retire_q |=> !retire_q); // R2
  AST_ACC_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(in_ex && step == EXEC_STEP) |=> $stable(acc_q)); // R3
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
    zero_q == (acc_q == '0)); // R3
  AST_STORE_SLOT: assert property (@(posedge clk) disable iff (rst)
    (cpu_own && ram_we) |-> (in_ex && step == EXEC_STEP)); // R4
  AST_AREG_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(in_ex && step == EXEC_STEP) |=> $stable(areg_q)); // R5
endmodule

// File: tb/test_acc4_cpu.sv
module test_acc4_cpu;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, run, ld_we, nmi_req;
  logic [7:0] ld_addr, ld_wdata, ld_rdata, nmi_vec, pc_o, areg_o;
  logic [3:0] acc_o;
  logic       zero_o, retire;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc4_cpu i_acc4_cpu (
    .clk(clk), .rst(rst), .run(run), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_wdata(ld_wdata), .ld_rdata(ld_rdata), .nmi_req(nmi_req), .nmi_vec(nmi_vec),
    .acc_o(acc_o), .zero_o(zero_o), .pc_o(pc_o), .areg_o(areg_o), .retire(retire)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); ld_we = 1'b1; ld_addr = a; ld_wdata = d;
    @(negedge clk); ld_we = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); ld_addr = a;
    @(negedge clk); d = ld_rdata;
  endtask

  task automatic wipe();
    for (int a = 0; a < 256; a++) poke(8'(a), 8'h00);
  endtask

  task automatic boot();
    @(negedge clk); rst = 1'b1; run = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0; run = 1'b1;
  endtask

  task automatic park();
    run = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  // Waits for the next retire pulse; returns the cycles waited
  task automatic wait_retire(output int n);
    n = 0;
    do begin
      @(negedge clk); n++;
    end while (!retire && n < 40);
    if (!retire) chk("R2 retire timeout", 0, 1);
  endtask

  task automatic t_reset();
    int n;
    @(negedge clk); rst = 1'b1; run = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 pc", pc_o, 0); chk("R1 acc", acc_o, 0);
    chk("R1 areg", areg_o, 0); chk("R1 zero", zero_o, 1);
    n = 0;
    repeat (20) begin @(negedge clk); if (retire) n++; end
    chk("R1 parked retire", n, 0); chk("R1 parked pc", pc_o, 0);
  endtask

  task automatic t_loadport();
    logic [7:0] d;
    poke(8'h9A, 8'h5C); poke(8'h9B, 8'hE3);
    peek(8'h9A, d); chk("R9 readback a", d, 8'h5C);
    peek(8'h9B, d); chk("R9 readback b", d, 8'hE3);
  endtask

  task automatic t_arith();
    int n;
    wipe();
    poke(8'h00, 8'hD2); poke(8'h01, 8'h09); poke(8'h02, 8'h0C);
    poke(8'h21, 8'h01); poke(8'h22, 8'h22); poke(8'h23, 8'h57);
    poke(8'h24, 8'h32); poke(8'h25, 8'h16); poke(8'h26, 8'h41); poke(8'h27, 8'hB7);
    boot();
    wait_retire(n); chk("R6 high nibble jump", pc_o, 8'h21);
    wait_retire(n); chk("R2 instruction gap", n, 6);
    chk("R3 load mem", acc_o, 9); chk("R2 pc increment", pc_o, 8'h22);
    wait_retire(n); chk("R3 add mem wrap", acc_o, 5);
    wait_retire(n); chk("R3 sub imm wrap", acc_o, 14);
    wait_retire(n); chk("R3 add to zero", acc_o, 0); chk("R3 zero flag set", zero_o, 1);
    wait_retire(n); chk("R3 load imm", acc_o, 6); chk("R3 zero flag clear", zero_o, 0);
    wait_retire(n); chk("R3 sub mem", acc_o, 13);
    park();
  endtask

  task automatic t_store();
    int n;
    logic [7:0] d;
    wipe();
    poke(8'h00, 8'hD2); poke(8'h04, 8'h50);
    poke(8'h21, 8'h1A); poke(8'h22, 8'h73); poke(8'h23, 8'h64); poke(8'h24, 8'hB4);
    boot();
    repeat (4) wait_retire(n);
    chk("R4 acc kept after store", acc_o, 10);
    park();
    peek(8'h03, d); chk("R4 direct store", d, 8'h0A);
    peek(8'h50, d); chk("R4 indirect store", d, 8'h0A);
    peek(8'h04, d); chk("R4 pointer untouched", d, 8'h50);
  endtask

  task automatic t_areg();
    int n;
    wipe();
    poke(8'h00, 8'hD2); poke(8'h05, 8'hA7);
    poke(8'h21, 8'h9C); poke(8'h22, 8'h85); poke(8'h23, 8'hB3);
    boot();
    wait_retire(n);
    wait_retire(n); chk("R5 areg immediate", areg_o, 8'h0C);
    wait_retire(n); chk("R5 areg from mem", areg_o, 8'hA7);
    park();
  endtask

  task automatic t_jumps();
    int n;
    wipe();
    poke(8'h00, 8'hD2); poke(8'h06, 8'h73); poke(8'h07, 8'h5E);
    poke(8'h21, 8'hB8); poke(8'h28, 8'hC6); poke(8'h39, 8'hD4);
    poke(8'h4A, 8'hA7); poke(8'h4E, 8'hBE);
    boot();
    wait_retire(n);
    wait_retire(n); chk("R6 low nibble imm", pc_o, 8'h28);
    wait_retire(n); chk("R6 high nibble mem", pc_o, 8'h39);
    wait_retire(n); chk("R6 high nibble imm", pc_o, 8'h4A);
    wait_retire(n); chk("R6 low nibble mem", pc_o, 8'h4E);
    park();
  endtask

  task automatic t_cond();
    int n;
    wipe();
    poke(8'h00, 8'hD2); poke(8'h08, 8'h60);
    poke(8'h21, 8'h13); poke(8'h22, 8'hE8); poke(8'h23, 8'h53); poke(8'h24, 8'hE8);
    poke(8'h60, 8'h13); poke(8'h61, 8'hFF); poke(8'h62, 8'h10); poke(8'h63, 8'hFF);
    poke(8'h0F, 8'hD3); poke(8'h30, 8'hB0);
    boot();
    repeat (2) wait_retire(n);
    wait_retire(n); chk("R7 mem jump not taken", pc_o, 8'h23);
    wait_retire(n);
    wait_retire(n); chk("R7 mem jump taken", pc_o, 8'h60);
    wait_retire(n);
    wait_retire(n); chk("R7 imm jump not taken", pc_o, 8'h62);
    wait_retire(n);
    wait_retire(n); chk("R7 imm jump taken", pc_o, 8'h0F);
    wait_retire(n); chk("R7 landing executes", pc_o, 8'h30);
    park();
  endtask

  task automatic t_nmi();
    int n;
    bit hit;
    wipe();
    poke(8'h00, 8'hD2);
    poke(8'h21, 8'h15); poke(8'h22, 8'hB1);
    poke(8'h70, 8'h1C); poke(8'h71, 8'hB1);
    nmi_vec = 8'h70;
    boot();
    repeat (3) wait_retire(n);
    chk("R8 no jump without request", pc_o, 8'h21);
    @(negedge clk); nmi_req = 1'b1;
    hit = 1'b0;
    for (int k = 0; k < 3 && !hit; k++) begin
      wait_retire(n);
      if (pc_o == 8'h70) hit = 1'b1;
    end
    chk("R8 vector taken at instruction end", hit, 1);
    chk("R8 prior instruction completed", acc_o, 5);
    wait_retire(n); chk("R8 handler runs", acc_o, 12); chk("R8 handler pc", pc_o, 8'h71);
    for (int k = 0; k < 6; k++) begin
      wait_retire(n);
      if (pc_o != 8'h71) chk("R8 single jump per edge", pc_o, 8'h71);
    end
    chk("R8 held request no rejump", pc_o, 8'h71);
    nmi_req = 1'b0;
    park();
  endtask

  initial begin
    rst = 1'b1; run = 1'b0; ld_we = 1'b0; ld_addr = '0; ld_wdata = '0;
    nmi_req = 1'b0; nmi_vec = '0;
    t_reset();
    t_loadport();
    t_arith();
    t_store();
    t_areg();
    t_jumps();
    t_cond();
    t_nmi();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired got 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule